// File: doc/BRIEF.md
# Reference Clock Input Predivider

This block conditions a single reference clock before it reaches a phase-locked loop. It runs in the reference clock's own domain. It turns that clock into a stream of single-cycle enable pulses, spaced by a divide ratio chosen from the configuration inputs. A downstream loop treats each pulse as one edge of the divided reference.

Two mode bits and a 4-bit rate code select the ratio together:

- **Direct lock** passes every cycle.
- **Fixed 8 kHz** divides whatever nominal rate the code names down to 8 kHz.
- **Programmable** divides by a shared value plus one.
- **Alternate direct** reinterprets the code as one of four higher rates and divides each to a supported rate.

A rate-select input chooses between the 1544 kHz and 2048 kHz meanings of one code. Combinations that cannot produce a legal result raise an invalid flag and silence the pulse stream.

The sequencer has three named states:

- **LOAD**: counter cleared because the configuration just changed.
- **COUNT**: counting towards the terminal value.
- **FAULT**: configuration invalid, counter held at zero.

The transitions are:

- **restart**: any state goes to LOAD when the sampled configuration differs from the held copy.
- **settle**: the block goes to COUNT when the configuration is unchanged and valid.
- **reject**: the block goes to FAULT when the configuration is unchanged and invalid.

Top module: `refclk_prediv`

## Requirements
- R1: While `rst_n` is low, `clk_en` and `cfg_invalid` are both 0.
- R2: With mode `{cfg_prog,cfg_fix8k}` = 00, every code from 0000 to 1101 gives ratio 1, so `clk_en` is high on every cycle once settled.
- R3: With mode 01, the ratio is the nominal rate divided by 8 kHz. The codes map as follows:
  - 0000 gives 1.
  - 0001 gives 193 when `rate_sel`=1 (1544 kHz) and 256 when `rate_sel`=0 (2048 kHz).
  - 0010 gives 810.
  - 0011 gives 2430.
  - 0100 gives 3240.
  - 0101 gives 4860.
  - 0110 gives 6480.
  - 0111 gives 9720.
  - 1000 gives 19440.
  - 1011 gives 789.
  - 1100 gives 625.
- R4: With mode 01, codes 1001 (2 kHz) and 1010 (4 kHz) ignore the fixed-8 kHz bit. They pass undivided with ratio 1 and no invalid flag.
- R5: With mode 10, the ratio is `div_n`+1 for any code from 0000 to 1101.
- R6: With mode 11, code 0000 gives ratio 2, 0001 gives 5, 0010 gives 2 and 0011 gives 4. Every other code is invalid.
- R7: `cfg_invalid` rises in the cycle after a configuration is sampled when any of these holds:
  - the code is 1110 or 1111 in modes 00, 01 or 10;
  - the code is 1101 in mode 01;
  - the code is anything other than 0000 to 0011 in mode 11.
- R8: While `cfg_invalid` is high, `clk_en` is low.
- R9: A change of any configuration input may come from `cfg_prog`, `cfg_fix8k`, `cfg_code`, `rate_sel` or `div_n`. When it is sampled at edge E, `clk_en` is low after E and the counter restarts. The first pulse follows edge E+F, where F is the new ratio, and pulses then recur every F cycles.
- R10: When the ratio is 2 or more, each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prog | input | 1 | Mode bit: programmable / alternate selection |
| cfg_fix8k | input | 1 | Mode bit: fixed 8 kHz / alternate selection |
| cfg_code | input | 4 | Nominal rate code |
| rate_sel | input | 1 | 1 = 1544 kHz, 0 = 2048 kHz meaning of code 0001 |
| div_n | input | DIV_W | Shared divide value N (ratio N+1) |
| clk_en | output | 1 | Single-cycle enable pulse per divided period |
| cfg_invalid | output | 1 | Current configuration has no legal ratio |

## Verification
The hardest situation to reach from the ports is a restart landing on the exact cycle a long ratio would have wrapped. A second hard case is a rate-select or shared-value change while the mode makes that input look irrelevant, since it must still restart the count. Random segments therefore hold short ratios for a few full periods and switch at random points. Directed runs walk the long fixed-8 kHz ratios through at least one complete period, and a measured first-pulse latency checks the restart distance exactly.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'b00,
        MODE_FIX8K  = 2'b01,
        MODE_PROG   = 2'b10,
        MODE_ALT    = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FAULT = 2'd2
    } seq_state_e;

    localparam int RATIO_W = 15;

    // Ratio to 8 kHz for each nominal code; zero marks no legal ratio.
    function automatic logic [RATIO_W-1:0] ratio_to_8k(input logic [3:0] code,
                                                       input logic       sel_1544);
        logic [RATIO_W-1:0] r;
        unique case (code)
            4'd0:    r = 15'd1;
            4'd1:    r = sel_1544 ? 15'd193 : 15'd256;
            4'd2:    r = 15'd810;
            4'd3:    r = 15'd2430;
            4'd4:    r = 15'd3240;
            4'd5:    r = 15'd4860;
            4'd6:    r = 15'd6480;
            4'd7:    r = 15'd9720;
            4'd8:    r = 15'd19440;
            4'd9:    r = 15'd1;
            4'd10:   r = 15'd1;
            4'd11:   r = 15'd789;
            4'd12:   r = 15'd625;
            default: r = '0;
        endcase
        return r;
    endfunction

    // Alternate direct decode; zero marks an undefined code.
    function automatic logic [2:0] ratio_alt(input logic [3:0] code);
        logic [2:0] r;
        unique case (code)
            4'd0:    r = 3'd2;
            4'd1:    r = 3'd5;
            4'd2:    r = 3'd2;
            4'd3:    r = 3'd4;
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pdiv_decode.sv
module pdiv_decode
    import pdiv_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int CNT_W = 17
) (
    input  logic [1:0]       mode_i,
    input  logic [3:0]       code_i,
    input  logic             sel_1544_i,
    input  logic [DIV_W-1:0] div_n_i,
    output logic [CNT_W-1:0] ratio_o,
    output logic             bad_o
);
    mode_e              mode;
    logic               std_undef;
    logic [RATIO_W-1:0] r8k;
    logic [2:0]         ralt;

    assign mode      = mode_e'(mode_i);
    assign std_undef = (code_i >= 4'd14);
    assign r8k       = ratio_to_8k(code_i, sel_1544_i);
    assign ralt      = ratio_alt(code_i);

    always_comb begin
        ratio_o = CNT_W'(1);
        bad_o   = 1'b0;
        unique case (mode)
            MODE_DIRECT: begin
                bad_o = std_undef;
            end
            MODE_FIX8K: begin
                bad_o = (r8k == '0);
                if (!bad_o) ratio_o = CNT_W'(r8k);
            end
            MODE_PROG: begin
                bad_o   = std_undef;
                ratio_o = CNT_W'(div_n_i) + CNT_W'(1);
            end
            MODE_ALT: begin
                bad_o = (ralt == '0);
                if (!bad_o) ratio_o = CNT_W'(ralt);
            end
            default: begin
                bad_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pdiv_cfg_track.sv
module pdiv_cfg_track #(
    parameter int CFG_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_i,
    output logic [CFG_W-1:0] cfg_q,
    output logic             changed_o
);
    assign changed_o = (cfg_i != cfg_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_i;
    end
endmodule

// File: rtl/pdiv_seq.sv
module pdiv_seq
    import pdiv_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             changed_i,
    input  logic             bad_i,
    input  logic [CNT_W-1:0] ratio_i,
    output logic             pulse_o
);
    seq_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             at_term;

    assign at_term = (cnt == ratio_i - CNT_W'(1));

    // Transitions: restart -> LOAD, reject -> FAULT, settle -> COUNT.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD, ST_COUNT, ST_FAULT: begin
                if (changed_i)  state_nx = ST_LOAD;
                else if (bad_i) state_nx = ST_FAULT;
                else            state_nx = ST_COUNT;
            end
            default: state_nx = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOAD;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            pulse_o <= 1'b0;
        end else begin
            unique case (state_nx)
                ST_COUNT: begin
                    pulse_o <= at_term;
                    cnt     <= at_term ? '0 : cnt + CNT_W'(1);
                end
                ST_LOAD, ST_FAULT: begin
                    pulse_o <= 1'b0;
                    cnt     <= '0;
                end
                default: begin
                    pulse_o <= 1'b0;
                    cnt     <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/refclk_prediv.sv
module refclk_prediv
    import pdiv_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_prog,
    input  logic             cfg_fix8k,
    input  logic [3:0]       cfg_code,
    input  logic             rate_sel,
    input  logic [DIV_W-1:0] div_n,
    output logic             clk_en,
    output logic             cfg_invalid
);
    localparam int CNT_W = (DIV_W + 1 > RATIO_W) ? DIV_W + 1 : RATIO_W;
    localparam int CFG_W = DIV_W + 7;

    logic [CFG_W-1:0] cfg_in, cfg_hold;
    logic             changed;
    logic [CNT_W-1:0] ratio;
    logic             bad;

    assign cfg_in = {cfg_prog, cfg_fix8k, cfg_code, rate_sel, div_n};

    pdiv_cfg_track #(.CFG_W(CFG_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_i     (cfg_in),
        .cfg_q     (cfg_hold),
        .changed_o (changed)
    );

    pdiv_decode #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_decode (
        .mode_i     (cfg_hold[CFG_W-1 -: 2]),
        .code_i     (cfg_hold[DIV_W+1 +: 4]),
        .sel_1544_i (cfg_hold[DIV_W]),
        .div_n_i    (cfg_hold[DIV_W-1:0]),
        .ratio_o    (ratio),
        .bad_o      (bad)
    );

    pdiv_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .changed_i (changed),
        .bad_i     (bad),
        .ratio_i   (ratio),
        .pulse_o   (clk_en)
    );

    assign cfg_invalid = bad;
endmodule

// File: rtl/pdiv_checker.sv
module pdiv_checker #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_prog,
    input logic             cfg_fix8k,
    input logic [3:0]       cfg_code,
    input logic             rate_sel,
    input logic [DIV_W-1:0] div_n,
    input logic             clk_en,
    input logic             cfg_invalid
);
    logic [DIV_W+6:0] cfg_vec;
    logic             armed;

    assign cfg_vec = {cfg_prog, cfg_fix8k, cfg_code, rate_sel, div_n};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R8
    a_r8_fault_blocks_en: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_invalid |-> !clk_en);

    // R9
    a_r9_change_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cfg_vec != $past(cfg_vec)) |=> !clk_en);

    // R2
    a_r2_direct_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !cfg_prog && !cfg_fix8k && cfg_code < 4'd14 && cfg_vec == $past(cfg_vec))
        |=> clk_en);

    // R6
    a_r6_alt_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && cfg_prog && cfg_fix8k) |=> !clk_en);

    // R7
    a_r7_code13_fix8k_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_prog && cfg_fix8k && cfg_code == 4'd13) |=> cfg_invalid);
endmodule

bind refclk_prediv pdiv_checker #(.DIV_W(DIV_W)) u_pdiv_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_prog    (cfg_prog),
    .cfg_fix8k   (cfg_fix8k),
    .cfg_code    (cfg_code),
    .rate_sel    (rate_sel),
    .div_n       (div_n),
    .clk_en      (clk_en),
    .cfg_invalid (cfg_invalid)
);

// File: tb/test_refclk_prediv.sv
module test_refclk_prediv;
    localparam int DIV_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_prog = 1'b0;
    logic             cfg_fix8k = 1'b0;
    logic [3:0]       cfg_code = 4'd0;
    logic             rate_sel = 1'b0;
    logic [DIV_W-1:0] div_n = '0;
    logic             clk_en;
    logic             cfg_invalid;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    refclk_prediv #(.DIV_W(DIV_W)) i_refclk_prediv (
        .clk(clk), .rst_n(rst_n), .cfg_prog(cfg_prog), .cfg_fix8k(cfg_fix8k),
        .cfg_code(cfg_code), .rate_sel(rate_sel), .div_n(div_n),
        .clk_en(clk_en), .cfg_invalid(cfg_invalid)
    );

    always #5 clk = ~clk;

    // Expected ratio from the requirements; 0 means invalid.
    function automatic int exp_ratio(bit p, bit f, bit [3:0] c, bit rs, int n);
        int khz;
        if (!p && !f) return (c >= 14) ? 0 : 1;                    // R2
        if (p && !f)  return (c >= 14) ? 0 : n + 1;                // R5
        if (p && f) begin                                          // R6
            case (c)
                4'd0: return 2;
                4'd1: return 5;
                4'd2: return 2;
                4'd3: return 4;
                default: return 0;
            endcase
        end
        if (c == 9 || c == 10) return 1;                           // R4
        case (c)                                                   // R3
            4'd0:  khz = 8;
            4'd1:  khz = rs ? 1544 : 2048;
            4'd2:  khz = 6480;
            4'd3:  khz = 19440;
            4'd4:  khz = 25920;
            4'd5:  khz = 38880;
            4'd6:  khz = 51840;
            4'd7:  khz = 77760;
            4'd8:  khz = 155520;
            4'd11: khz = 6312;
            4'd12: khz = 5000;
            default: khz = 0;                                      // R7
        endcase
        return khz / 8;
    endfunction

    // Cycle model of the requirements
    logic [DIV_W+6:0] m_prev;
    int  m_cnt;
    bit  m_en, m_inv, m_last_en;
    int  m_ratio;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_prev = '0; m_cnt = 0; m_en = 0; m_inv = 0; m_ratio = 1;
        end else begin
            logic [DIV_W+6:0] cur;
            cur = {cfg_prog, cfg_fix8k, cfg_code, rate_sel, div_n};
            m_ratio = exp_ratio(cfg_prog, cfg_fix8k, cfg_code, rate_sel, int'(div_n));
            m_inv = (m_ratio == 0);
            if (cur != m_prev) begin            // R9 restart
                m_cnt = 0; m_en = 0;
            end else if (m_inv) begin           // R8
                m_cnt = 0; m_en = 0;
            end else begin
                m_en = (m_cnt == m_ratio - 1);
                m_cnt = m_en ? 0 : m_cnt + 1;
            end
            m_prev = cur;
        end
    end

    function automatic string tag_now();
        if (m_inv) return "R7";
        if (!cfg_prog && !cfg_fix8k) return "R2";
        if (!cfg_prog && cfg_fix8k) return (cfg_code == 9 || cfg_code == 10) ? "R4" : "R3";
        if (cfg_prog && !cfg_fix8k) return "R5";
        return "R6";
    endfunction

    task automatic step();
        @(negedge clk);
        n_vec++;
        if (clk_en !== m_en) begin
            n_bad++;
            $display("FAIL %s clk_en actual=%0b expected=%0b", m_inv ? "R8" : tag_now(), clk_en, m_en);
        end
        if (cfg_invalid !== m_inv) begin
            n_bad++;
            $display("FAIL R7 cfg_invalid actual=%0b expected=%0b", cfg_invalid, m_inv);
        end
        if (m_ratio >= 2 && clk_en && m_last_en) begin
            n_bad++;
            $display("FAIL R10 pulse width actual=2+ expected=1");
        end
        m_last_en = clk_en;
    endtask

    task automatic apply(bit p, bit f, bit [3:0] c, bit rs, int n);
        cfg_prog = p; cfg_fix8k = f; cfg_code = c; rate_sel = rs; div_n = DIV_W'(n);
    endtask

    task automatic hold(int cycles);
        for (int i = 0; i < cycles; i++) step();
    endtask

    task automatic run(bit p, bit f, bit [3:0] c, bit rs, int n, int cycles);
        apply(p, f, c, rs, n);
        hold(cycles);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            n_vec++;
            if (clk_en !== 1'b0 || cfg_invalid !== 1'b0) begin
                n_bad++;
                $display("FAIL R1 reset outputs actual=%0b%0b expected=00", clk_en, cfg_invalid);
            end
        end
        rst_n = 1'b1;
        hold(4);

        // Directed corners
        run(0, 0, 4'd3, 0, 0, 6);                 // R2 direct
        run(0, 0, 4'd15, 0, 0, 5);                // R7 undefined code
        run(0, 1, 4'd13, 0, 0, 5);                // R7 31.25 MHz in fixed 8k
        run(0, 1, 4'd9, 0, 0, 5);                 // R4 2 kHz override
        run(0, 1, 4'd10, 0, 0, 5);                // R4 4 kHz override
        run(0, 1, 4'd1, 1, 0, 2*193 + 3);         // R3 1544 kHz
        run(0, 1, 4'd1, 0, 0, 2*256 + 3);         // R3 2048 kHz, R9 rate_sel change
        run(0, 1, 4'd2, 0, 0, 2*810 + 3);
        run(0, 1, 4'd3, 0, 0, 2*2430 + 3);
        run(0, 1, 4'd11, 0, 0, 2*789 + 3);
        run(0, 1, 4'd12, 0, 0, 2*625 + 3);
        run(0, 1, 4'd8, 0, 0, 19440 + 3);
        for (int c = 0; c < 16; c++) run(1, 1, 4'(c), 0, 0, 12);  // R6 full sweep
        run(1, 0, 4'd0, 0, 0, 6);                 // R5 N=0
        run(1, 0, 4'd0, 0, 7, 20);                // R5 N change restarts

        // R9: first-pulse latency after a change
        begin
            int first_k;
            apply(1, 0, 4'd5, 0, 4);
            first_k = 0;
            for (int k = 1; k <= 8; k++) begin
                step();
                if (clk_en && first_k == 0) first_k = k;
            end
            n_vec++;
            if (first_k != 6) begin
                n_bad++;
                $display("FAIL R9 first pulse negedge actual=%0d expected=6", first_k);
            end
        end

        // Constrained random segments
        for (int s = 0; s < 400; s++) begin
            bit p, f, rs;
            bit [3:0] c;
            int n, r, len;
            p  = 1'($urandom);
            f  = 1'($urandom);
            rs = 1'($urandom);
            c  = ($urandom % 8 == 0) ? 4'(13 + $urandom % 3) : 4'($urandom % 13);
            if (p && f) c = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 4);
            n  = ($urandom % 8 == 0) ? int'($urandom % 300) : int'($urandom % 12);
            if (!p && f && $urandom % 2 == 0) c = 4'(($urandom % 2) ? 0 : 9 + $urandom % 2);
            r  = exp_ratio(p, f, c, rs, n);
            len = (r > 0 && r <= 300 && $urandom % 3 == 0) ? 2*r + 2 + int'($urandom % 5)
                                                             : 1 + int'($urandom % 30);
            run(p, f, c, rs, n, len);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule